// File: doc/BRIEF.md
# DDR Transmit Lane Serializer with Forwarded Clock

This block is the digital core of one transmit slice of a die-to-die parallel link. Link-layer logic hands it one wide word per parallel-clock cycle, and the block spreads that word over sixteen single-ended data lanes and, when enabled, two side lanes for error-correction and auxiliary bits. Each lane runs at double data rate against the fast transmit clock. The block forwards a gated copy of that clock next to the lanes so the receiver can capture source-synchronously. The analog drivers are outside this block. The fast clock and its inverted copy arrive as plain logic inputs.

The block derives the parallel clock itself by dividing the fast clock by N/2, where N is the number of serial slots each lane carries per word (2, 4 or 8). A word is taken on the fast-clock rising edge on which the parallel clock rises. It leaves on the lanes starting one fast cycle later. An active-low synchronous reset silences the slice. A ready output tells the link layer when words are being accepted. An idle request, sampled only at word boundaries, lets the word in flight finish and then parks the lanes low and stops the forwarded clock. The parallel clock keeps running so the link layer can end the idle state.

Top module: `ddr_tx_slice`

## Requirements
- R1: Data lane i carries, in serial slot k of a word, input bit `data_i[i*N + k]`; slot 0 is sent first and slots follow in ascending order.
- R2: A word taken at boundary edge E puts slot 2j on the lanes during the high phase after fast rising edge E+1+j, and slot 2j+1 during the following low phase, for j = 0 .. N/2-1. Consecutive words follow with no gap.
- R3: When the side lanes are enabled, the error-correction lane and the auxiliary lane send `fec_i[k]` and `aux_i[k]` in slot k, with the same timing as the data lanes and without any interpretation.
- R4: `pclk_o` has a period of N/2 fast cycles and is high for the first half of it. Its rising edges coincide with the fast rising edges at which words are taken (boundary edges).
- R5: While `rst_n` is sampled low, `ready_o`, `pclk_o`, the forwarded clock and every lane are driven low, starting no later than one full fast cycle after the first low sample.
- R6: After reset is released, `ready_o` stays low at the first fast rising edge. It goes high at the second one, which is also the first rising edge of `pclk_o`, provided `idle_i` is low there.
- R7: While the slice is running, `fwd_clk_o` follows the fast clock: high in its high phase and low in its low phase.
- R8: When `idle_i` is high at a boundary edge, `ready_o` goes low at that edge and the word in flight still completes. From the next fast rising edge on, the lanes stay low and the forwarded clock stays low. The incoming word and any later input data are dropped. `pclk_o` keeps toggling.
- R9: `idle_i` has no effect at fast rising edges that are not boundary edges.
- R10: When `idle_i` is low at a boundary edge in the idle state, `ready_o` rises at that edge. The forwarded clock stays low for that high phase, then resumes at the next fast rising edge, together with slot 0 of the word taken at that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tx | input | 1 | Fast transmit clock |
| clk_tx_n | input | 1 | Inverted copy of the fast transmit clock, used for falling-edge launch |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_i | input | 1 | Idle request, sampled at boundary edges only |
| data_i | input | 16*N | Parallel data word; lane i occupies bits [i*N +: N] |
| fec_i | input | N | Error-correction lane bits for one word |
| aux_i | input | N | Auxiliary lane bits for one word |
| pclk_o | output | 1 | Divided parallel clock for the link layer |
| ready_o | output | 1 | High while words are accepted |
| fwd_clk_o | output | 1 | Forwarded, gated transmit clock |
| lane_o | output | 16 | Serial data lanes |
| fec_lane_o | output | 1 | Serial error-correction lane |
| aux_lane_o | output | 1 | Serial auxiliary lane |

## Verification
A slot counter that is out of step shows within one word as bits landing in the wrong half-cycle or on the wrong lane. A shifted boundary shows as a `pclk_o` rising edge that does not line up with the word-taking edge. A wrong run or gate state shows within one or two fast cycles of an idle or resume boundary: the forwarded clock keeps pulsing, falls silent too early, or cuts off the last two slots of the word in flight. A reset path left out of any register shows on the lanes or the forwarded clock within a single fast cycle of asserting reset.

// File: rtl/ddr_tx_pkg.sv
// ddr_tx_pkg: shared constants and helpers for the transmit slice.
// Assumes N (serial slots per word) is one of 2, 4 or 8.
package ddr_tx_pkg;

    localparam int DATA_LANES = 16;

    // Number of lanes including the optional side pair.
    function automatic int total_lanes(input bit side_en);
        return DATA_LANES + (side_en ? 2 : 0);
    endfunction

    // Width of a phase counter counting to ratio-1 (at least one bit).
    function automatic int phase_bits(input int ratio);
        return (ratio > 1) ? $clog2(ratio) : 1;
    endfunction

endpackage

// File: rtl/ddr_tx_pacer.sv
// ddr_tx_pacer: word-phase sequencing for the slice.
// Divides the fast clock by N/2 to make the parallel clock, marks the
// boundary edge at which a word is taken, tracks the running/idle state
// and gates the forwarded clock on the falling edge so it never glitches.
// Assumes clk_tx_n is the exact inverse of clk_tx.
module ddr_tx_pacer #(
    parameter int N = 4
) (
    input  logic                                   clk_tx,
    input  logic                                   clk_tx_n,
    input  logic                                   rst_n,
    input  logic                                   idle_i,
    output logic                                   pclk_o,
    output logic                                   ready_o,
    output logic                                   fwd_clk_o,
    output logic                                   load_o,
    output logic                                   fill_o,
    output logic [ddr_tx_pkg::phase_bits(N/2)-1:0] phase_o
);
    localparam int DIV = N / 2;
    localparam int PW  = ddr_tx_pkg::phase_bits(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic          alive_q;
    logic          run_q;
    logic          gate_q;
    logic [PW-1:0] phase_q;
    logic          boundary;

    assign boundary = alive_q && (phase_q == LAST);

    // Marks that reset has been released for at least one edge.
    always_ff @(posedge clk_tx) begin
        if (!rst_n) alive_q <= 1'b0;
        else        alive_q <= 1'b1;
    end

    // Slot-pair counter; parked at its last value until alive.
    always_ff @(posedge clk_tx) begin
        if (!rst_n)              phase_q <= LAST;
        else if (alive_q) begin
            if (phase_q == LAST) phase_q <= '0;
            else                 phase_q <= phase_q + PW'(1);
        end
    end

    // Running state, updated only at word boundaries from the idle request.
    always_ff @(posedge clk_tx) begin
        if (!rst_n)        run_q <= 1'b0;
        else if (boundary) run_q <= !idle_i;
    end

    // Clock-enable for the forwarded clock, changed while the clock is low.
    always_ff @(posedge clk_tx_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= run_q;
    end

    // Parallel clock: a gated copy for ratio one, else high in the first half.
    generate
        if (DIV == 1) begin : g_pclk_pass
            assign pclk_o = clk_tx & alive_q;
        end else begin : g_pclk_div
            assign pclk_o = alive_q && (phase_q < PW'(DIV / 2));
        end
    endgenerate

    assign fwd_clk_o = clk_tx & gate_q;
    assign ready_o   = run_q;
    assign load_o    = boundary;
    assign fill_o    = boundary && !idle_i;
    assign phase_o   = phase_q;

endmodule

// File: rtl/ddr_lane_ser.sv
// ddr_lane_ser: one double-data-rate lane.
// Holds the N bits of the current word, launches even slots from a
// rising-edge flop and odd slots from a falling-edge flop, and muxes the
// two by clock level. Assumes load_i pulses once per word at the boundary
// edge and phase_i counts slot pairs 0..N/2-1 after it.
module ddr_lane_ser #(
    parameter int N = 4
) (
    input  logic                                   clk_tx,
    input  logic                                   clk_tx_n,
    input  logic                                   rst_n,
    input  logic                                   load_i,
    input  logic                                   fill_i,
    input  logic [ddr_tx_pkg::phase_bits(N/2)-1:0] phase_i,
    input  logic [N-1:0]                           bits_i,
    output logic                                   lane_o
);
    localparam int PAIRS = N / 2;

    logic [N-1:0]     word_q;
    logic [PAIRS-1:0] even_bits;
    logic [PAIRS-1:0] odd_bits;
    logic [PAIRS-1:0] even_sel;
    logic [PAIRS-1:0] odd_sel;
    logic             hi_q;
    logic             lo_pend_q;
    logic             lo_q;

    // Split the word into rising-edge and falling-edge slot groups.
    generate
        for (genvar j = 0; j < PAIRS; j++) begin : g_pair
            assign even_bits[j] = word_q[2*j];
            assign odd_bits[j]  = word_q[2*j+1];
        end
    endgenerate

    assign even_sel = even_bits >> phase_i;
    assign odd_sel  = odd_bits >> phase_i;

    // Word holder; a dropped word becomes all zeros.
    always_ff @(posedge clk_tx) begin
        if (!rst_n)      word_q <= '0;
        else if (load_i) word_q <= fill_i ? bits_i : '0;
    end

    // Rising-edge launch of the even slot and staging of the odd slot.
    always_ff @(posedge clk_tx) begin
        if (!rst_n) begin
            hi_q      <= 1'b0;
            lo_pend_q <= 1'b0;
        end else begin
            hi_q      <= even_sel[0];
            lo_pend_q <= odd_sel[0];
        end
    end

    // Falling-edge launch of the odd slot.
    always_ff @(posedge clk_tx_n) begin
        if (!rst_n) lo_q <= 1'b0;
        else        lo_q <= lo_pend_q;
    end

    assign lane_o = clk_tx ? hi_q : lo_q;

endmodule

// File: rtl/ddr_tx_slice.sv
// ddr_tx_slice: top of the transmit slice.
// One pacer drives the word phase for sixteen data lanes and, if SIDE_EN
// is set, the error-correction and auxiliary lanes. Assumes N in {2,4,8};
// with SIDE_EN clear the side inputs are ignored and the side lanes held low.
module ddr_tx_slice #(
    parameter int N       = 4,
    parameter bit SIDE_EN = 1'b1
) (
    input  logic                                clk_tx,
    input  logic                                clk_tx_n,
    input  logic                                rst_n,
    input  logic                                idle_i,
    input  logic [ddr_tx_pkg::DATA_LANES*N-1:0] data_i,
    input  logic [N-1:0]                        fec_i,
    input  logic [N-1:0]                        aux_i,
    output logic                                pclk_o,
    output logic                                ready_o,
    output logic                                fwd_clk_o,
    output logic [ddr_tx_pkg::DATA_LANES-1:0]   lane_o,
    output logic                                fec_lane_o,
    output logic                                aux_lane_o
);
    localparam int DL = ddr_tx_pkg::DATA_LANES;
    localparam int PW = ddr_tx_pkg::phase_bits(N / 2);

    logic          word_edge;
    logic          word_fill;
    logic [PW-1:0] slot_phase;

    ddr_tx_pacer #(.N(N)) u_pacer (
        .clk_tx    (clk_tx),
        .clk_tx_n  (clk_tx_n),
        .rst_n     (rst_n),
        .idle_i    (idle_i),
        .pclk_o    (pclk_o),
        .ready_o   (ready_o),
        .fwd_clk_o (fwd_clk_o),
        .load_o    (word_edge),
        .fill_o    (word_fill),
        .phase_o   (slot_phase)
    );

    // One serializer per data lane.
    generate
        for (genvar i = 0; i < DL; i++) begin : g_data
            ddr_lane_ser #(.N(N)) u_lane (
                .clk_tx   (clk_tx),
                .clk_tx_n (clk_tx_n),
                .rst_n    (rst_n),
                .load_i   (word_edge),
                .fill_i   (word_fill),
                .phase_i  (slot_phase),
                .bits_i   (data_i[i*N +: N]),
                .lane_o   (lane_o[i])
            );
        end
    endgenerate

    // Side lanes present or tied off, chosen by SIDE_EN.
    generate
        if (SIDE_EN) begin : g_side
            ddr_lane_ser #(.N(N)) u_fec (
                .clk_tx   (clk_tx),
                .clk_tx_n (clk_tx_n),
                .rst_n    (rst_n),
                .load_i   (word_edge),
                .fill_i   (word_fill),
                .phase_i  (slot_phase),
                .bits_i   (fec_i),
                .lane_o   (fec_lane_o)
            );
            ddr_lane_ser #(.N(N)) u_aux (
                .clk_tx   (clk_tx),
                .clk_tx_n (clk_tx_n),
                .rst_n    (rst_n),
                .load_i   (word_edge),
                .fill_i   (word_fill),
                .phase_i  (slot_phase),
                .bits_i   (aux_i),
                .lane_o   (aux_lane_o)
            );
        end else begin : g_noside
            assign fec_lane_o = 1'b0;
            assign aux_lane_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/ddr_tx_slice_chk.sv
// ddr_tx_slice_chk: protocol checks on the ready/idle handshake, bound to
// the slice top. Uses the boundary strobe the pacer drives.
module ddr_tx_slice_chk (
    input logic clk_tx,
    input logic rst_n,
    input logic idle_i,
    input logic ready_o,
    input logic word_edge
);
    // R6: ready is still low at the first edge after reset release.
    a_r6_no_early_ready: assert property (@(posedge clk_tx) disable iff (!rst_n)
        (rst_n && !$past(rst_n)) |-> !ready_o);

    // R8: idle sampled at a boundary drops ready.
    a_r8_idle_drops_ready: assert property (@(posedge clk_tx) disable iff (!rst_n)
        (word_edge && idle_i) |=> !ready_o);

    // R9: away from boundaries ready never changes.
    a_r9_ready_holds: assert property (@(posedge clk_tx) disable iff (!rst_n)
        !word_edge |=> ready_o == $past(ready_o));

    // R10: a boundary with idle low leaves the slice running.
    a_r10_resume: assert property (@(posedge clk_tx) disable iff (!rst_n)
        (word_edge && !idle_i) |=> ready_o);

endmodule

bind ddr_tx_slice ddr_tx_slice_chk u_chk (
    .clk_tx    (clk_tx),
    .rst_n     (rst_n),
    .idle_i    (idle_i),
    .ready_o   (ready_o),
    .word_edge (word_edge)
);

// File: tb/tb_ddr_tx_slice.sv
module tb_ddr_tx_slice;
    localparam int N = 4;

    logic        clk_tx = 1'b0;
    logic        clk_tx_n;
    logic        rst_n;
    logic        idle_i;
    logic [63:0] data_i;
    logic [3:0]  fec_i;
    logic [3:0]  aux_i;
    logic        pclk_o, ready_o, fwd_clk_o, fec_lane_o, aux_lane_o;
    logic [15:0] lane_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk_tx = ~clk_tx;
    assign clk_tx_n = ~clk_tx;

    ddr_tx_slice #(.N(N), .SIDE_EN(1'b1)) dut (
        .clk_tx(clk_tx), .clk_tx_n(clk_tx_n), .rst_n(rst_n), .idle_i(idle_i),
        .data_i(data_i), .fec_i(fec_i), .aux_i(aux_i),
        .pclk_o(pclk_o), .ready_o(ready_o), .fwd_clk_o(fwd_clk_o),
        .lane_o(lane_o), .fec_lane_o(fec_lane_o), .aux_lane_o(aux_lane_o)
    );

    // {data, fec, aux} stimulus words
    localparam logic [71:0] VECS [6] = '{
        {64'h0123_4567_89AB_CDEF, 4'h5, 4'hA},
        {64'hFFFF_FFFF_FFFF_FFFF, 4'hF, 4'hF},
        {64'h0000_0000_0000_0000, 4'h0, 4'h0},
        {64'hAAAA_5555_AAAA_5555, 4'h6, 4'h9},
        {64'h8421_8421_8421_8421, 4'h1, 4'h8},
        {64'hF0F0_0F0F_F0F0_0F0F, 4'h3, 4'hC}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [15:0] data_slot(input logic [63:0] d, input int k);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = d[i*N + k];
        return r;
    endfunction

    // Checks one full word on the lanes after the boundary that took it.
    task automatic expect_word(input logic [63:0] d, input logic [3:0] f, input logic [3:0] a);
        for (int j = 0; j < N/2; j++) begin
            @(posedge clk_tx); #2;
            chk("R1/R2 even slot data", lane_o, data_slot(d, 2*j));
            chk("R3 even slot side", {aux_lane_o, fec_lane_o}, {a[2*j], f[2*j]});
            chk("R7 fwd high phase", fwd_clk_o, 1'b1);
            @(negedge clk_tx); #2;
            chk("R1/R2 odd slot data", lane_o, data_slot(d, 2*j+1));
            chk("R3 odd slot side", {aux_lane_o, fec_lane_o}, {a[2*j+1], f[2*j+1]});
            chk("R7 fwd low phase", fwd_clk_o, 1'b0);
        end
    endtask

    initial begin
        rst_n = 1'b0; idle_i = 1'b0; data_i = '0; fec_i = '0; aux_i = '0;

        // R5: reset state
        repeat (3) @(posedge clk_tx);
        #2;
        chk("R5 ready in reset", ready_o, 1'b0);
        chk("R5 pclk in reset", pclk_o, 1'b0);
        chk("R5 fwd in reset", fwd_clk_o, 1'b0);
        chk("R5 lanes in reset", {aux_lane_o, fec_lane_o, lane_o}, 18'h0);

        // R6 / R4: start-up
        @(negedge clk_tx); #1 rst_n = 1'b1;
        @(posedge clk_tx); #2;
        chk("R6 ready after first edge", ready_o, 1'b0);
        chk("R4 pclk before first boundary", pclk_o, 1'b0);
        @(posedge clk_tx); #2;
        chk("R6 ready at first boundary", ready_o, 1'b1);
        chk("R4 pclk rises at boundary", pclk_o, 1'b1);
        @(posedge clk_tx); #2;
        chk("R4 pclk second half low", pclk_o, 1'b0);
        @(posedge clk_tx); #2;
        chk("R4 pclk period N/2", pclk_o, 1'b1);

        // Table walk: R1, R2, R3, R7
        for (int v = 0; v < 6; v++) begin
            {data_i, fec_i, aux_i} = VECS[v];
            @(posedge pclk_o);
            expect_word(VECS[v][71:8], VECS[v][7:4], VECS[v][3:0]);
        end

        // R8: idle at a boundary
        data_i = 64'h1357_9BDF_2468_ACE0; fec_i = 4'h9; aux_i = 4'h6;
        @(posedge pclk_o);
        #1 idle_i = 1'b1;
        @(posedge pclk_o); #2;
        chk("R8 ready drops", ready_o, 1'b0);
        chk("R8 in-flight slot2", lane_o, data_slot(64'h1357_9BDF_2468_ACE0, 2));
        chk("R8 fwd still high", fwd_clk_o, 1'b1);
        data_i = '1; fec_i = '1; aux_i = '1;
        @(negedge clk_tx); #2;
        chk("R8 in-flight slot3", lane_o, data_slot(64'h1357_9BDF_2468_ACE0, 3));
        @(posedge clk_tx); #2;
        chk("R8 fwd stopped", fwd_clk_o, 1'b0);
        chk("R8 lanes low", {aux_lane_o, fec_lane_o, lane_o}, 18'h0);
        @(posedge pclk_o); #2;
        chk("R8 pclk keeps running", pclk_o, 1'b1);
        @(posedge clk_tx); #2;
        chk("R8 input ignored, lanes low", {aux_lane_o, fec_lane_o, lane_o}, 18'h0);
        chk("R8 fwd stays low", fwd_clk_o, 1'b0);

        // R10: resume
        data_i = 64'hDEAD_BEEF_CAFE_F00D; fec_i = 4'hC; aux_i = 4'h3;
        idle_i = 1'b0;
        @(posedge pclk_o); #2;
        chk("R10 ready back", ready_o, 1'b1);
        chk("R10 fwd not yet", fwd_clk_o, 1'b0);
        expect_word(64'hDEAD_BEEF_CAFE_F00D, 4'hC, 4'h3);

        // R9: idle pulse away from a boundary
        idle_i = 1'b1;
        @(posedge clk_tx); #2 idle_i = 1'b0;
        @(posedge pclk_o); #2;
        chk("R9 ready unaffected", ready_o, 1'b1);
        chk("R9 fwd unaffected", fwd_clk_o, 1'b1);
        chk("R9 lanes carry word", lane_o, data_slot(64'hDEAD_BEEF_CAFE_F00D, 2));

        // R5: reset while running
        #1 rst_n = 1'b0;
        @(negedge clk_tx); #2;
        chk("R5 lanes low after falling edge", {aux_lane_o, fec_lane_o, lane_o}, 18'h0);
        @(posedge clk_tx); #2;
        chk("R5 fwd low", fwd_clk_o, 1'b0);
        chk("R5 ready low", ready_o, 1'b0);
        chk("R5 pclk low", pclk_o, 1'b0);
        chk("R5 lanes low high phase", {aux_lane_o, fec_lane_o, lane_o}, 18'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk_tx);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule